// File: doc/BRIEF.md
# Endpoint Queue Interrupt Aggregator

This block gathers the completion and error events raised by a set of per-endpoint transmit and receive queue engines and folds them into a small bank of status registers, each paired with an enable mask, plus one interrupt line toward the processor. Every event arrives as a one-cycle pulse on a per-endpoint bit of a per-kind input vector. The seven event kinds are transmit done, receive done, receive checksum error, receive length error, receive zero-length error, transmit checksum error and transmit length error.

Software uses a simple register port. A write strobe and a read strobe share one word address, and read data is combinational in the cycle of the strobe. Completion bits are always captured, and their enable mask only decides what software sees. Error bits are captured only while their per-endpoint enable bit is set. A five-bit class summary records which error classes have fired since it was last read, and the read clears it. Endpoint 0 carries no queue traffic and never produces a bit.

Top module: `epq_irq_agg`

## Requirements
- R1: After reset every status, enable and summary register reads as zero and `irq_o` is low.
- R2: Word address 0 is the completion register. A transmit-done pulse for endpoint n sets bit n, and a receive-done pulse for endpoint n sets bit 16+n. Word address 1 is its enable mask, with the same layout.
- R3: A read of address 0 returns only the completion bits whose enable bit is set. A captured bit that is masked stays stored and shows up once its enable bit is written to 1.
- R4: In every status register (addresses 0, 4, 6 and 8), writing a 1 clears that bit and writing a 0 leaves it unchanged.
- R5: An error pulse is stored only if the matching bit of its enable register is set in that cycle. With the enable bit clear, the status bit and the summary both stay at zero.
- R6: Error layout: address 4 holds receive checksum errors in [15:0] and receive length errors in [31:16]. Address 6 holds receive zero-length errors in [15:0]. Address 8 holds transmit checksum errors in [15:0] and transmit length errors in [31:16]. The enable registers sit at addresses 5, 7 and 9 with the same layout. Unmapped addresses read as zero.
- R7: Address 2 is the class summary: bit 0 receive checksum, bit 1 receive length, bit 2 receive zero-length, bit 3 transmit checksum, bit 4 transmit length. A class bit is set in the cycle after an error of that class is stored. A read returns the summary and then clears it.
- R8: If an error of some class is stored in the same cycle as a summary read, that class bit is still set after the read.
- R9: Endpoint 0 is ignored. Bit 0 and bit 16 of every status and enable register always read as zero, whatever the pulses or writes.
- R10: When an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit remains set.
- R11: `irq_o` is a register. It goes high one cycle after any enabled completion bit or any summary bit is set, and it goes low one cycle after all of them are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done_i | input | NUM_EP | Per-endpoint transmit completion pulses |
| rx_done_i | input | NUM_EP | Per-endpoint receive completion pulses |
| rx_cserr_i | input | NUM_EP | Per-endpoint receive checksum error pulses |
| rx_lenerr_i | input | NUM_EP | Per-endpoint receive length error pulses |
| rx_zlperr_i | input | NUM_EP | Per-endpoint receive zero-length error pulses |
| tx_cserr_i | input | NUM_EP | Per-endpoint transmit checksum error pulses |
| tx_lenerr_i | input | NUM_EP | Per-endpoint transmit length error pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the summary at address 2) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the strobe cycle |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a hardware event and a software write-one-to-clear on the same status bit. The second pair is a summary read-clear and a newly stored error of some class. The bench provokes each pair by raising the event pulse in the very cycle that carries the write or read strobe. It then judges the outcome through a later register read: the status bit must still be 1, and the summary must return its old value in the strobe cycle and then keep only the class that arrived with the read. The same overlaps are also watched cycle by cycle by properties on the stored vectors.

// File: rtl/epq_irq_pkg.sv
package epq_irq_pkg;

  localparam int FIELD_W   = 16;
  localparam int KINDS     = 7;
  localparam int CLASSES   = 5;
  localparam int FIRST_ERR = 2;

  // event kinds; error kinds are in summary-class order
  localparam int K_TX_DONE = 0;
  localparam int K_RX_DONE = 1;
  localparam int K_RX_CS   = 2;
  localparam int K_RX_LEN  = 3;
  localparam int K_RX_ZLP  = 4;
  localparam int K_TX_CS   = 5;
  localparam int K_TX_LEN  = 6;

  localparam logic [3:0] A_DONE    = 4'd0;
  localparam logic [3:0] A_DONE_EN = 4'd1;
  localparam logic [3:0] A_SUM     = 4'd2;
  localparam logic [3:0] A_RXE     = 4'd4;
  localparam logic [3:0] A_RXE_EN  = 4'd5;
  localparam logic [3:0] A_ZLP     = 4'd6;
  localparam logic [3:0] A_ZLP_EN  = 4'd7;
  localparam logic [3:0] A_TXE     = 4'd8;
  localparam logic [3:0] A_TXE_EN  = 4'd9;

  function automatic logic is_done(int k);
    return (k < FIRST_ERR);
  endfunction

  function automatic logic [3:0] stat_addr(int k);
    case (k)
      K_TX_DONE, K_RX_DONE: return A_DONE;
      K_RX_CS, K_RX_LEN:    return A_RXE;
      K_RX_ZLP:             return A_ZLP;
      default:              return A_TXE;
    endcase
  endfunction

  // every enable register sits one word above its status register
  function automatic logic [3:0] en_addr(int k);
    return stat_addr(k) + 4'd1;
  endfunction

  function automatic int field_lsb(int k);
    case (k)
      K_RX_DONE, K_RX_LEN, K_TX_LEN: return FIELD_W;
      default:                       return 0;
    endcase
  endfunction

  // endpoints 1..n-1 are live; endpoint 0 never carries queue events
  function automatic logic [FIELD_W-1:0] live_mask(int n);
    logic [FIELD_W-1:0] m;
    m = '0;
    for (int i = 1; i < FIELD_W; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [31:0] place(logic [FIELD_W-1:0] v, int lsb);
    return 32'(v) << lsb;
  endfunction

endpackage

// File: rtl/epq_en_reg.sv
module epq_en_reg #(
  parameter int         W    = 16,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (we_i) q <= d_i & LIVE;
  end

  assign q_o = q;
endmodule

// File: rtl/epq_sticky_bank.sv
module epq_sticky_bank #(
  parameter int         W    = 16,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] gate_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rec_o
);
  logic [W-1:0] q;
  logic [W-1:0] rec;
  logic [W-1:0] clr_eff;

  assign rec     = evt_i & gate_i & LIVE;
  assign clr_eff = clr_we_i ? clr_i : '0;

  // a new event outranks a clear aimed at the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_eff) | rec;
  end

  assign q_o   = q;
  assign rec_o = rec;
endmodule

// File: rtl/epq_class_summary.sv
module epq_class_summary #(
  parameter int C = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [C-1:0] cls_evt_i,
  input  logic         rd_clr_i,
  output logic [C-1:0] q_o
);
  logic [C-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (rd_clr_i ? '0 : q) | cls_evt_i;
  end

  assign q_o = q;
endmodule

// File: rtl/epq_irq_agg.sv
module epq_irq_agg
  import epq_irq_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] tx_done_i,
  input  logic [NUM_EP-1:0] rx_done_i,
  input  logic [NUM_EP-1:0] rx_cserr_i,
  input  logic [NUM_EP-1:0] rx_lenerr_i,
  input  logic [NUM_EP-1:0] rx_zlperr_i,
  input  logic [NUM_EP-1:0] tx_cserr_i,
  input  logic [NUM_EP-1:0] tx_lenerr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int              HALF = FIELD_W;
  localparam logic [HALF-1:0] LIVE = live_mask(NUM_EP);

  logic [KINDS-1:0][HALF-1:0] ev_vec;
  logic [KINDS-1:0][HALF-1:0] stat_q;
  logic [KINDS-1:0][HALF-1:0] en_q;
  logic [KINDS-1:0][HALF-1:0] rec;

  // named internal events, observed by the bound checker
  logic [KINDS*HALF-1:0] stat_flat;
  logic [KINDS*HALF-1:0] en_flat;
  logic [KINDS*HALF-1:0] rec_flat;
  logic [2*HALF-1:0]     done_vis;
  logic [CLASSES-1:0]    cls_evt;
  logic [CLASSES-1:0]    sum_q;
  logic                  sum_rd;
  logic                  irq_d;
  logic                  irq_q;

  always_comb begin
    ev_vec            = '0;
    ev_vec[K_TX_DONE] = HALF'(tx_done_i);
    ev_vec[K_RX_DONE] = HALF'(rx_done_i);
    ev_vec[K_RX_CS]   = HALF'(rx_cserr_i);
    ev_vec[K_RX_LEN]  = HALF'(rx_lenerr_i);
    ev_vec[K_RX_ZLP]  = HALF'(rx_zlperr_i);
    ev_vec[K_TX_CS]   = HALF'(tx_cserr_i);
    ev_vec[K_TX_LEN]  = HALF'(tx_lenerr_i);
  end

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    localparam int         LSB = field_lsb(k);
    localparam logic [3:0] SA  = stat_addr(k);
    localparam logic [3:0] EA  = en_addr(k);
    logic [HALF-1:0] gate;

    epq_en_reg #(.W(HALF), .LIVE(LIVE)) en_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (reg_wr_i && (reg_addr_i == EA)),
      .d_i   (reg_wdata_i[LSB +: HALF]),
      .q_o   (en_q[k])
    );

    if (is_done(k)) begin : g_done
      // completions are always captured; the mask only hides them
      assign gate = '1;
    end else begin : g_err
      assign gate = en_q[k];
    end

    epq_sticky_bank #(.W(HALF), .LIVE(LIVE)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (ev_vec[k]),
      .gate_i   (gate),
      .clr_we_i (reg_wr_i && (reg_addr_i == SA)),
      .clr_i    (reg_wdata_i[LSB +: HALF]),
      .q_o      (stat_q[k]),
      .rec_o    (rec[k])
    );
  end

  for (genvar c = 0; c < CLASSES; c++) begin : g_cls
    assign cls_evt[c] = |rec[FIRST_ERR + c];
  end

  assign sum_rd = reg_rd_i && (reg_addr_i == A_SUM);

  epq_class_summary #(.C(CLASSES)) sum_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls_evt_i (cls_evt),
    .rd_clr_i  (sum_rd),
    .q_o       (sum_q)
  );

  assign stat_flat = stat_q;
  assign en_flat   = en_q;
  assign rec_flat  = rec;
  assign done_vis  = {stat_q[K_RX_DONE] & en_q[K_RX_DONE],
                      stat_q[K_TX_DONE] & en_q[K_TX_DONE]};

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_SUM) reg_rdata_o = 32'(sum_q);
    for (int k = 0; k < KINDS; k++) begin
      if (reg_addr_i == stat_addr(k))
        reg_rdata_o |= place(is_done(k) ? (stat_q[k] & en_q[k]) : stat_q[k],
                             field_lsb(k));
      if (reg_addr_i == en_addr(k))
        reg_rdata_o |= place(en_q[k], field_lsb(k));
    end
  end

  assign irq_d = (|done_vis) || (|sum_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/epq_irq_agg_chk.sv
module epq_irq_agg_chk
  import epq_irq_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr_i,
  input logic                       reg_rd_i,
  input logic [3:0]                 reg_addr_i,
  input logic [31:0]                reg_wdata_i,
  input logic [31:0]                reg_rdata_o,
  input logic                       irq_o,
  input logic [2*FIELD_W-1:0]       done_vis,
  input logic [CLASSES-1:0]         sum_q,
  input logic [CLASSES-1:0]         cls_evt,
  input logic [KINDS*FIELD_W-1:0]   stat_flat,
  input logic [KINDS*FIELD_W-1:0]   en_flat,
  input logic [KINDS*FIELD_W-1:0]   rec_flat
);
  localparam int DW = 2 * FIELD_W;
  localparam int EW = KINDS * FIELD_W - DW;

  // R11: interrupt is the registered OR of visible completions and summary
  a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past((|done_vis) || (|sum_q)));

  // R10: a stored event is present the cycle after, whatever was written
  a_r10_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|rec_flat) |=> ((stat_flat & $past(rec_flat)) == $past(rec_flat)));

  // R5: an error bit only rises where its enable bit was set
  a_r5_gated_capture: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_flat[KINDS*FIELD_W-1:DW] & ~$past(stat_flat[KINDS*FIELD_W-1:DW])
               & ~$past(en_flat[KINDS*FIELD_W-1:DW])) == EW'(0)));

  // R4: written ones clear completion bits unless an event refills them
  a_r4_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_DONE) |=>
      ((stat_flat[DW-1:0] & $past(reg_wdata_i) & ~$past(rec_flat[DW-1:0])) == '0));

  // R7: a read with no new class event leaves the summary empty
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == A_SUM && cls_evt == '0) |=> (sum_q == '0));

  // R8: a class arriving with the read survives it
  a_r8_event_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == A_SUM && (|cls_evt)) |=>
      ((sum_q & $past(cls_evt)) == $past(cls_evt)));

  // R9: endpoint 0 never appears in the completion register
  a_r9_ep0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == A_DONE) |-> (reg_rdata_o[0] == 1'b0 && reg_rdata_o[FIELD_W] == 1'b0));
endmodule

bind epq_irq_agg epq_irq_agg_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .done_vis    (done_vis),
  .sum_q       (sum_q),
  .cls_evt     (cls_evt),
  .stat_flat   (stat_flat),
  .en_flat     (en_flat),
  .rec_flat    (rec_flat)
);

// File: tb/epq_irq_agg_tb_top.sv
`timescale 1ns/1ps
module epq_irq_agg_tb_top;
  localparam int NEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0][NEP-1:0] ev_b = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  epq_irq_agg #(.NUM_EP(NEP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_done_i(ev_b[0]), .rx_done_i(ev_b[1]),
    .rx_cserr_i(ev_b[2]), .rx_lenerr_i(ev_b[3]), .rx_zlperr_i(ev_b[4]),
    .tx_cserr_i(ev_b[5]), .tx_lenerr_i(ev_b[6]),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input int k, input int ep);
    @(negedge clk); ev_b[k][ep] = 1'b1;
    @(negedge clk); ev_b = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 10; a++) begin
      rd_reg(4'(a), v);
      check($sformatf("R1 reset addr %0d", a), v, 32'h0);
    end
    check("R1 reset irq", 32'(irq), 32'h0);
  endtask

  task automatic t_done_pack();
    logic [31:0] v;
    wr_reg(4'd1, 32'hFFFF_FFFF);
    pulse(0, 3);
    check("R11 irq not yet", 32'(irq), 32'h0);
    @(negedge clk);
    check("R11 irq one cycle later", 32'(irq), 32'h1);
    pulse(1, 5);
    rd_reg(4'd0, v);
    check("R2 done packing", v, (32'h1 << 3) | (32'h1 << 21));
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr_reg(4'd0, 32'h1 << 3);
    rd_reg(4'd0, v);
    check("R4 w1c tx bit", v, 32'h1 << 21);
    wr_reg(4'd0, 32'h0);
    rd_reg(4'd0, v);
    check("R4 zero write no effect", v, 32'h1 << 21);
    wr_reg(4'd0, 32'h1 << 21);
    check("R11 irq still high at clear", 32'(irq), 32'h1);
    @(negedge clk);
    check("R11 irq low after clear", 32'(irq), 32'h0);
    rd_reg(4'd0, v);
    check("R4 w1c rx bit", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr_reg(4'd1, 32'h0);
    pulse(0, 2);
    @(negedge clk);
    check("R11 masked done no irq", 32'(irq), 32'h0);
    rd_reg(4'd0, v);
    check("R3 masked hidden", v, 32'h0);
    wr_reg(4'd1, 32'h4);
    rd_reg(4'd0, v);
    check("R3 revealed by enable", v, 32'h4);
    wr_reg(4'd0, 32'h4);
    wr_reg(4'd1, 32'hFFFF_FFFF);
    rd_reg(4'd1, v);
    check("R9 done enable ep0 bits", v, 32'hFFFE_FFFE);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    pulse(2, 1);
    rd_reg(4'd4, v);
    check("R5 disabled error dropped", v, 32'h0);
    rd_reg(4'd2, v);
    check("R5 disabled error no summary", v, 32'h0);
    wr_reg(4'd5, 32'hFFFF_FFFF);
    wr_reg(4'd7, 32'h0000_FFFF);
    wr_reg(4'd9, 32'hFFFF_FFFF);
    rd_reg(4'd7, v);
    check("R9 zlp enable ep0 bit", v, 32'h0000_FFFE);
    pulse(2, 1); pulse(3, 2); pulse(4, 3); pulse(5, 4); pulse(6, 5);
    rd_reg(4'd4, v);
    check("R6 rx cs/len layout", v, 32'h0004_0002);
    rd_reg(4'd6, v);
    check("R6 rx zlp layout", v, 32'h0000_0008);
    rd_reg(4'd8, v);
    check("R6 tx cs/len layout", v, 32'h0020_0010);
    rd_reg(4'd3, v);
    check("R6 unmapped reads zero", v, 32'h0);
    rd_reg(4'd2, v);
    check("R7 summary all classes", v, 32'h1F);
    rd_reg(4'd2, v);
    check("R7 summary cleared by read", v, 32'h0);
    wr_reg(4'd4, 32'h0004_0000);
    rd_reg(4'd4, v);
    check("R4 w1c error reg", v, 32'h0000_0002);
  endtask

  task automatic t_ep0();
    logic [31:0] v;
    pulse(0, 0); pulse(1, 0); pulse(2, 0);
    rd_reg(4'd0, v);
    check("R9 ep0 done ignored", v, 32'h0);
    rd_reg(4'd4, v);
    check("R9 ep0 error ignored", v, 32'h0000_0002);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(0, 6);
    @(negedge clk); wr = 1'b1; addr = 4'd0; wdata = 32'h40; ev_b[0][6] = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0; ev_b = '0;
    rd_reg(4'd0, v);
    check("R10 done set beats clear", v, 32'h40);
    wr_reg(4'd0, 32'h40);
    rd_reg(4'd0, v);
    check("R10 done cleared alone", v, 32'h0);
    @(negedge clk); wr = 1'b1; addr = 4'd8; wdata = 32'h10; ev_b[5][4] = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0; ev_b = '0;
    rd_reg(4'd8, v);
    check("R10 error set beats clear", v, 32'h0020_0010);
    wr_reg(4'd8, 32'h0020_0010);
    rd_reg(4'd8, v);
    check("R4 tx errors cleared", v, 32'h0);
    rd_reg(4'd2, v);
    check("R7 tx cs class from collision", v, 32'h08);
  endtask

  task automatic t_sum_race();
    logic [31:0] v;
    pulse(6, 1);
    @(negedge clk); rd = 1'b1; addr = 4'd2; ev_b[4][7] = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0; ev_b = '0;
    check("R8 read returns old summary", v, 32'h10);
    rd_reg(4'd2, v);
    check("R8 same-cycle class kept", v, 32'h04);
    check("R11 irq from summary", 32'(irq), 32'h1);
    @(negedge clk);
    check("R11 irq low after summary clear", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_done_pack();
    t_w1c();
    t_mask();
    t_errors();
    t_ep0();
    t_collide();
    t_sum_race();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule